// File: doc/BRIEF.md
# Safe Gray-Code Decade Counter

This block is a modulo-10 counter whose state lives in a 4-bit Gray-style code. When enabled, it steps one position per clock, either upward or downward. A registered decode stage turns the state into an unsigned count from 0 to 9 and marks that count valid. It is meant for control paths where a flipped state bit must not leak into downstream logic as an out-of-range count, and must not leave the counter stuck on a wrong sequence.

Six of the sixteen possible codes are unused. If the state register ever holds one of them, the counter flags it during that cycle and returns to the count-0 code on the next clock, whatever the enable and direction inputs are. While the state is illegal, the output register keeps the last legal count and drops its valid flag, so a value above 9 never appears at the output. Correcting an upset is not part of this block; it only detects illegal states and recovers from them.

For verification, an XOR mask input is folded into the next-state value. It injects bit upsets into the state register through the normal port list. In normal use the mask is tied to zero.

Top module: `safe_gray_decade`

## Requirements
- R1: While `rst_i` is high at a clock edge, the state returns to the count-0 code. After that edge `count_o` reads 0, `valid_o` reads 1 and `illegal_o` reads 0.
- R2: With `en_i`=1 and `up_i`=1, the count advances 0,1,...,9 and then wraps from 9 to 0. `count_o` shows each count one clock after the state holds it.
- R3: With `en_i`=1 and `up_i`=0, the count steps down by one per clock and wraps from 0 to 9.
- R4: With `en_i`=0 and a legal state, the state and `count_o` hold their values.
- R5: A state holding an unused code becomes the count-0 code (0000) at the next clock edge, whatever `en_i` and `up_i` are.
- R6: `illegal_o` is high in exactly those cycles in which the state holds one of the six unused codes: 1001, 1010, 1011, 1101, 1110 and 1111.
- R7: `count_o` is loaded only from a legal state and never exceeds 9. On the clock after an illegal state, `count_o` keeps its previous value and `valid_o` is 0. On the clock after a legal state, `valid_o` is 1.
- R8: The code for counts 0 to 9 is, in order: 0000, 0001, 0011, 0010, 0110, 0111, 0101, 0100, 1100, 1000. Each enabled step, including the wrap between 9 and 0, changes exactly one state bit.
- R9: The bits of `upset_mask_i` are XORed into the value that is loaded into the state register at each edge. Bit i of the mask flips state bit i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_i | input | 1 | Synchronous reset, active high |
| en_i | input | 1 | Count enable |
| up_i | input | 1 | Direction: 1 counts up, 0 counts down |
| upset_mask_i | input | 4 | Fault-injection mask XORed into the next state; tie to zero in use |
| count_o | output | 4 | Registered unsigned count, 0 to 9 |
| valid_o | output | 1 | High when `count_o` was loaded from a legal state on the last edge |
| illegal_o | output | 1 | High while the state register holds an unused code |

## Verification
The bench drives the counter into each of the six unused codes. It checks that recovery lands on count 0 even with the enable low. A design that honoured the enable in an illegal state would stay locked there. It also checks that the output keeps its old count rather than showing a decoded 10 to 15. Both wrap points are exercised in each direction, because a table error at 9 or at 0 would break the cycle into a shorter loop or a jump of two bits. Each legal code is also reached by a single injected mask, which exposes a swapped row in the encoding that plain counting would hide. The run ends with a long pseudo-random mix of enable, direction and upsets, compared cycle by cycle against a behavioural model.

// File: rtl/gdc_pkg.sv
package gdc_pkg;
  localparam int unsigned CODE_W   = 4;
  localparam int unsigned CNT_W    = 4;
  localparam int unsigned N_LEGAL  = 10;
  localparam int unsigned LAST_CNT = N_LEGAL - 1;

  typedef logic [CODE_W-1:0] code_t;
  typedef logic [CNT_W-1:0]  cnt_t;

  typedef struct packed {
    logic legal;
    cnt_t value;
  } dec_t;

  localparam code_t HOME_CODE = '0;

  // Gray code to count; unused codes report legal=0
  function automatic dec_t decode(code_t c);
    dec_t r;
    r.legal = 1'b1;
    unique case (c)
      4'b0000: r.value = 4'd0;
      4'b0001: r.value = 4'd1;
      4'b0011: r.value = 4'd2;
      4'b0010: r.value = 4'd3;
      4'b0110: r.value = 4'd4;
      4'b0111: r.value = 4'd5;
      4'b0101: r.value = 4'd6;
      4'b0100: r.value = 4'd7;
      4'b1100: r.value = 4'd8;
      4'b1000: r.value = 4'd9;
      default: begin
        r.legal = 1'b0;
        r.value = '0;
      end
    endcase
    return r;
  endfunction

  // One step in either direction, written per legal state
  function automatic code_t advance(code_t c, logic up);
    code_t n;
    unique case (c)
      4'b0000: n = up ? 4'b0001 : 4'b1000;
      4'b0001: n = up ? 4'b0011 : 4'b0000;
      4'b0011: n = up ? 4'b0010 : 4'b0001;
      4'b0010: n = up ? 4'b0110 : 4'b0011;
      4'b0110: n = up ? 4'b0111 : 4'b0010;
      4'b0111: n = up ? 4'b0101 : 4'b0110;
      4'b0101: n = up ? 4'b0100 : 4'b0111;
      4'b0100: n = up ? 4'b1100 : 4'b0101;
      4'b1100: n = up ? 4'b1000 : 4'b0100;
      4'b1000: n = up ? 4'b0000 : 4'b1100;
      default: n = HOME_CODE;
    endcase
    return n;
  endfunction
endpackage

// File: rtl/gdc_next.sv
module gdc_next
  import gdc_pkg::*;
(
  input  code_t state_i,
  input  logic  en_i,
  input  logic  up_i,
  input  code_t mask_i,
  output code_t next_o,
  output logic  legal_o
);
  dec_t  dec_w;
  code_t step_w;
  code_t base_w;

  always_comb begin
    dec_w   = decode(state_i);
    legal_o = dec_w.legal;
    step_w  = advance(state_i, up_i);
    if (!dec_w.legal)  base_w = HOME_CODE;
    else if (en_i)     base_w = step_w;
    else               base_w = state_i;
    next_o = base_w ^ mask_i;
  end
endmodule

// File: rtl/gdc_state_reg.sv
module gdc_state_reg
  import gdc_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_i,
  input  code_t d_i,
  output code_t q_o
);
  always_ff @(posedge clk_i) begin
    if (rst_i) q_o <= HOME_CODE;
    else       q_o <= d_i;
  end
endmodule

// File: rtl/gdc_out_stage.sv
module gdc_out_stage
  import gdc_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_i,
  input  code_t state_i,
  output cnt_t  count_o,
  output logic  valid_o
);
  dec_t dec_w;
  always_comb dec_w = decode(state_i);

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      count_o <= '0;
      valid_o <= 1'b1;
    end else begin
      valid_o <= dec_w.legal;
      if (dec_w.legal) count_o <= dec_w.value;
    end
  end

  assert_count_range_R7: assert property (@(posedge clk_i) disable iff (rst_i)
    count_o <= cnt_t'(LAST_CNT));
  assert_count_hold_R7: assert property (@(posedge clk_i) disable iff (rst_i)
    !dec_w.legal |=> ($stable(count_o) && !valid_o));
endmodule

// File: rtl/safe_gray_decade.sv
module safe_gray_decade
  import gdc_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             en_i,
  input  logic             up_i,
  input  logic [CODE_W-1:0] upset_mask_i,
  output logic [CNT_W-1:0]  count_o,
  output logic             valid_o,
  output logic             illegal_o
);
  code_t state_q;
  code_t next_w;
  logic  legal_w;

  gdc_next u_next (
    .state_i (state_q),
    .en_i    (en_i),
    .up_i    (up_i),
    .mask_i  (upset_mask_i),
    .next_o  (next_w),
    .legal_o (legal_w)
  );

  gdc_state_reg u_state (
    .clk_i (clk_i),
    .rst_i (rst_i),
    .d_i   (next_w),
    .q_o   (state_q)
  );

  gdc_out_stage u_out (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .state_i (state_q),
    .count_o (count_o),
    .valid_o (valid_o)
  );

  assign illegal_o = !legal_w;

  assert_recover_home_R5: assert property (@(posedge clk_i) disable iff (rst_i)
    (illegal_o && upset_mask_i == '0) |=> (state_q == HOME_CODE));
  assert_hold_idle_R4: assert property (@(posedge clk_i) disable iff (rst_i)
    (!illegal_o && !en_i && upset_mask_i == '0) |=> $stable(state_q));
  assert_single_bit_step_R8: assert property (@(posedge clk_i) disable iff (rst_i)
    (!illegal_o && en_i && upset_mask_i == '0) |=> ($countones(state_q ^ $past(state_q)) == 1));
  assert_flag_consistent_R6: assert property (@(posedge clk_i) disable iff (rst_i)
    illegal_o |-> (state_q[3] && (state_q[2:0] != 3'b100) && (state_q[2:0] != 3'b000)));
endmodule

// File: tb/test_safe_gray_decade.sv
module test_safe_gray_decade;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 200000;

  logic       clk_i = 1'b0;
  logic       rst_i = 1'b1;
  logic       en_i = 1'b0;
  logic       up_i = 1'b1;
  logic [3:0] upset_mask_i = 4'h0;
  logic [3:0] count_o;
  logic       valid_o;
  logic       illegal_o;

  safe_gray_decade i_safe_gray_decade (
    .clk_i(clk_i), .rst_i(rst_i), .en_i(en_i), .up_i(up_i),
    .upset_mask_i(upset_mask_i), .count_o(count_o),
    .valid_o(valid_o), .illegal_o(illegal_o)
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  int vectors = 0;
  int errors = 0;
  bit finished = 0;

  // reference model state
  logic [3:0] codes [10];
  logic [3:0] m_state;
  int         m_count;
  bit         m_valid;

  function automatic int index_of(logic [3:0] c);
    for (int i = 0; i < 10; i++) if (codes[i] == c) return i;
    return -1;
  endfunction

  task automatic check(string tag, string what, int act, int exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic step(bit en, bit up, logic [3:0] mask, bit rst, string tag);
    int idx;
    en_i = en; up_i = up; upset_mask_i = mask; rst_i = rst;
    @(posedge clk_i);
    idx = index_of(m_state);
    if (rst) begin
      m_state = codes[0]; m_count = 0; m_valid = 1;
    end else begin
      m_valid = (idx >= 0);
      if (idx >= 0) m_count = idx;
      if (idx < 0)      m_state = codes[0];
      else if (en)      m_state = codes[up ? (idx + 1) % 10 : (idx + 9) % 10];
      m_state = m_state ^ mask;
    end
    @(negedge clk_i);
    check(tag, "count_o", int'(count_o), m_count);
    check(tag, "valid_o", int'(valid_o), int'(m_valid));
    check(rst ? tag : "R6", "illegal_o", int'(illegal_o), int'(index_of(m_state) < 0));
  endtask

  initial begin
    #(CLK_PERIOD * WATCHDOG);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    logic [3:0] bad [6];
    int unsigned lf;
    codes = '{4'b0000, 4'b0001, 4'b0011, 4'b0010, 4'b0110,
              4'b0111, 4'b0101, 4'b0100, 4'b1100, 4'b1000};
    bad = '{4'b1001, 4'b1010, 4'b1011, 4'b1101, 4'b1110, 4'b1111};
    m_state = 4'b0000; m_count = 0; m_valid = 1;
    @(negedge clk_i);
    step(0, 1, 4'h0, 1, "R1");
    step(0, 1, 4'h0, 1, "R1");
    // R2: full up cycle with wrap 9 -> 0
    for (int i = 0; i < 23; i++) step(1, 1, 4'h0, 0, "R2");
    // R4: hold with enable low
    for (int i = 0; i < 4; i++) step(0, 0, 4'h0, 0, "R4");
    // R3: down cycle with wrap 0 -> 9
    for (int i = 0; i < 23; i++) step(1, 0, 4'h0, 0, "R3");
    // R8: each legal code reached from code 0 by one mask
    for (int k = 0; k < 10; k++) begin
      step(0, 1, 4'h0, 1, "R1");
      step(0, 1, codes[k], 0, "R9");
      step(0, 1, 4'h0, 0, "R8");
      step(0, 1, 4'h0, 0, "R8");
    end
    // R5 / R7: every unused code, recovery with enable low and high
    for (int k = 0; k < 6; k++) begin
      step(0, 1, 4'h0, 1, "R1");
      for (int j = 0; j < 3; j++) step(1, 1, 4'h0, 0, "R2");
      step(0, 1, bad[k] ^ codes[3], 0, "R9");
      step(k % 2 == 1, k < 3, 4'h0, 0, "R7");
      step(0, 1, 4'h0, 0, "R5");
      step(1, 1, 4'h0, 0, "R5");
    end
    // mixed pseudo-random traffic with occasional upsets
    step(0, 1, 4'h0, 1, "R1");
    lf = 32'h1234_5678;
    for (int i = 0; i < 600; i++) begin
      lf = lf * 1103515245 + 12345;
      step(lf[20] | lf[21], lf[22], (lf[27:25] == 3'b000) ? lf[19:16] : 4'h0,
           (lf[31:24] == 8'hff), "R9");
    end
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule